// File: doc/BRIEF.md
# SVGA Host Register Front End

This block sits between an 8-bit host port bus and the rest of a simple SVGA controller. It answers two read-only identification ports and an adapter enable port. It holds the CRT controller register file, reached through an index port and a data port, and it keeps the extended register window whose mode and bank registers place a 64 KB window into display memory.

The host issues single-cycle read or write strobes with a 16-bit port address. Read data comes combinationally from registered state. The timing generator reads the whole CRT controller file from a flat bus. When a data write changes a register that affects timing, the block raises a one-cycle pulse. The memory path takes the bank offset, which is given once for reads and once for writes.

Top module: `svga_host_regs`

## Requirements
- R1: A read of port 0x0100 returns 0xFE and a read of port 0x0101 returns 0xE8. Writes to either port change nothing.
- R2: Port 0x0102 holds an enable flag in bit 0. A write stores wdata bit 0. A read returns 0x00 or 0x01, and `adapter_en` follows the stored flag.
- R3: A write to index port 0x03D4 stores wdata bits 5:0. A read of 0x03D4 returns the stored index with bits 7:6 at zero.
- R4: While index bit 5 is set, writes to data port 0x03D5 change no register and a read of 0x03D5 returns 0xFF. While bit 5 is clear, a read returns the register that index bits 4:0 select.
- R5: While bit 7 of CRTC register 0x11 is set, data writes to registers 0 through 6 are discarded. A data write to register 7 takes only bit 4 from wdata and keeps the other seven bits.
- R6: `timing_recalc` is high for exactly the cycle after a data write that changes a stored value at an index outside 0x0E..0x10. In every other cycle it is low.
- R7: A write to mode port 0x2100 stores the byte. If the new low 3 bits are below 4, the bank offset becomes 0. Otherwise it becomes the stored bank bits 2:0 times 0x10000.
- R8: A write to bank port 0x2108 always stores the byte. It sets the offset to wdata bits 2:0 times 0x10000 only while the stored mode low bits are 4 or more. Otherwise the offset is unchanged.
- R9: `bank_rd_off` and `bank_wr_off` always carry the same value. Ports 0x2100, 0x2108 and 0x210A each read back the last byte written.
- R10: After reset, every register, the index, the enable flag, the bank offset and all CRTC registers are zero, and `timing_recalc` is low.
- R11: Any other port, including the unused ports of 0x2100..0x210F, reads 0x00 and ignores writes. `io_rdata` is 0x00 while `io_rd` is low.
- R12: CRTC register n appears on `crtc_regs` bits 8n+7:8n, for n from 0 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational |
| adapter_en | output | 1 | Stored enable flag |
| bank_rd_off | output | 19 | Byte offset of the read bank |
| bank_wr_off | output | 19 | Byte offset of the write bank |
| crtc_regs | output | 256 | Flat CRTC register file |
| timing_recalc | output | 1 | Pulse when a timing register changes |

## Verification
The bench goes after the write-protect edges. A lock that reaches one register too far or too short would corrupt register 7 or leave register 6 open, and a design that masks the wrong bit would change register 7 in full. It checks the pulse for writes that store the same value and for writes to the three cursor indices, where a wrong design would pulse for nothing. It also writes the bank register while the mode is linear and then raises the mode, where a wrong design would move the offset too early or lose the stored bank. The hidden-index reads and the unused window ports show a wrong decode as a wrong read value.

// File: rtl/svga_hif_pkg.sv
package svga_hif_pkg;
   localparam logic [15:0] PORT_ID_LO   = 16'h0100;
   localparam logic [15:0] PORT_ID_HI   = 16'h0101;
   localparam logic [15:0] PORT_ENABLE  = 16'h0102;
   localparam logic [15:0] PORT_CRT_IDX = 16'h03D4;
   localparam logic [15:0] PORT_CRT_DAT = 16'h03D5;
   localparam logic [15:0] PORT_MODE    = 16'h2100;
   localparam logic [15:0] PORT_BANK    = 16'h2108;
   localparam logic [15:0] PORT_AUX     = 16'h210A;

   localparam logic [7:0] ID_LO_VALUE   = 8'hFE;
   localparam logic [7:0] ID_HI_VALUE   = 8'hE8;
   localparam logic [7:0] HIDDEN_VALUE  = 8'hFF;

   localparam int LOCK_REG    = 17;   // register holding the protect flag
   localparam int LOCK_BIT    = 7;
   localparam int PROT_LAST   = 6;    // registers 0..6 fully locked
   localparam int PARTIAL_REG = 7;    // register with one open bit
   localparam int PARTIAL_BIT = 4;
   localparam int CUR_FIRST   = 14;   // cursor position range, no recalc
   localparam int CUR_LAST    = 16;
endpackage

// File: rtl/svga_adapter_id.sv
module svga_adapter_id (
   input  logic clk,
   input  logic rst_n,
   input  logic en_wr,
   input  logic en_wdata,
   output logic en_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     en_q <= 1'b0;
      else if (en_wr) en_q <= en_wdata;
   end
endmodule

// File: rtl/svga_crtc_file.sv
module svga_crtc_file #(
   parameter int IDX_W = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        idx_wr,
   input  logic [IDX_W-1:0]            idx_wdata,
   input  logic                        dat_wr,
   input  logic [7:0]                  wdata,
   output logic [IDX_W-1:0]            idx_q,
   output logic [7:0]                  dat_rd,
   output logic [8*(2**(IDX_W-1))-1:0] regs_flat,
   output logic                        recalc_q
);
   import svga_hif_pkg::*;

   localparam int SEL_W    = IDX_W - 1;
   localparam int NUM_REGS = 2**SEL_W;
   localparam logic [7:0] PART_MASK = 8'(1 << PARTIAL_BIT);

   initial begin
      assert (IDX_W >= 6 && IDX_W <= 8)
         else $error("IDX_W must cover the protect register and fit a byte");
   end

   logic [7:0]       regs_q [NUM_REGS];
   logic [SEL_W-1:0] sel;
   logic             hidden;
   logic             locked;
   logic [7:0]       cur;
   logic [7:0]       newv;
   logic             accept;
   logic             cursor;

   assign sel    = idx_q[SEL_W-1:0];
   assign hidden = idx_q[IDX_W-1];
   assign cur    = regs_q[sel];
   assign locked = regs_q[LOCK_REG][LOCK_BIT];
   assign cursor = (32'(sel) >= CUR_FIRST) && (32'(sel) <= CUR_LAST);

   always_comb begin
      newv   = wdata;
      accept = 1'b1;
      if (hidden) begin
         accept = 1'b0;
      end else if (locked && 32'(sel) <= PROT_LAST) begin
         accept = 1'b0;
      end else if (locked && 32'(sel) == PARTIAL_REG) begin
         newv = (cur & ~PART_MASK) | (wdata & PART_MASK);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      idx_q <= '0;
      else if (idx_wr) idx_q <= idx_wdata;
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs_q[i] <= 8'h00;
         else if (dat_wr && accept && 32'(sel) == i)
            regs_q[i] <= newv;
      end
      assign regs_flat[8*i +: 8] = regs_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) recalc_q <= 1'b0;
      else        recalc_q <= dat_wr && accept && (newv != cur) && !cursor;
   end

   assign dat_rd = hidden ? HIDDEN_VALUE : cur;

   AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> idx_q == $past(idx_wdata));                             // R3
   AST_HIDDEN_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr && hidden |=> $stable(regs_flat));                          // R4
   AST_LOCK_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr && !hidden && locked && 32'(sel) <= PROT_LAST |=> $stable(regs_flat)); // R5
   AST_CURSOR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr && cursor |=> !recalc_q);                                   // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !dat_wr |=> !recalc_q);                                            // R6
endmodule

// File: rtl/svga_ext_window.sv
module svga_ext_window #(
   parameter int BANK_BITS  = 3,
   parameter int PAGE_SHIFT = 16,
   parameter int MODE_W     = 3,
   parameter int MODE_MIN   = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          mode_wr,
   input  logic                          bank_wr,
   input  logic                          aux_wr,
   input  logic [7:0]                    wdata,
   output logic [7:0]                    mode_q,
   output logic [7:0]                    bank_q,
   output logic [7:0]                    aux_q,
   output logic [BANK_BITS+PAGE_SHIFT-1:0] bank_off
);
   localparam int OFF_W = BANK_BITS + PAGE_SHIFT;

   initial begin
      assert (BANK_BITS >= 1 && BANK_BITS <= 8) else $error("BANK_BITS out of range");
      assert (MODE_W >= 1 && MODE_W <= 8)       else $error("MODE_W out of range");
      assert (MODE_MIN < 2**MODE_W)             else $error("MODE_MIN unreachable");
   end

   logic banked;
   logic new_banked;

   assign banked     = 32'(mode_q[MODE_W-1:0]) >= MODE_MIN;
   assign new_banked = 32'(wdata[MODE_W-1:0]) >= MODE_MIN;

   function automatic logic [OFF_W-1:0] page_of(input logic [7:0] b);
      return {b[BANK_BITS-1:0], {PAGE_SHIFT{1'b0}}};
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= 8'h00;
         bank_q   <= 8'h00;
         aux_q    <= 8'h00;
         bank_off <= '0;
      end else begin
         if (mode_wr) begin
            mode_q   <= wdata;
            bank_off <= new_banked ? page_of(bank_q) : '0;
         end
         if (bank_wr) begin
            bank_q <= wdata;
            if (banked) bank_off <= page_of(wdata);
         end
         if (aux_wr) aux_q <= wdata;
      end
   end

   AST_FLAT_WHEN_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !banked |-> bank_off == '0);                                       // R7
   AST_BANK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      bank_wr && !banked && !mode_wr |=> $stable(bank_off));             // R8
   AST_BANK_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      bank_wr |=> bank_q == $past(wdata));                               // R8
endmodule

// File: rtl/svga_host_regs.sv
module svga_host_regs #(
   parameter int IDX_W      = 6,
   parameter int BANK_BITS  = 3,
   parameter int PAGE_SHIFT = 16,
   parameter bit GATE_RDATA = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [15:0]                     io_addr,
   input  logic [7:0]                      io_wdata,
   input  logic                            io_wr,
   input  logic                            io_rd,
   output logic [7:0]                      io_rdata,
   output logic                            adapter_en,
   output logic [BANK_BITS+PAGE_SHIFT-1:0] bank_rd_off,
   output logic [BANK_BITS+PAGE_SHIFT-1:0] bank_wr_off,
   output logic [8*(2**(IDX_W-1))-1:0]     crtc_regs,
   output logic                            timing_recalc
);
   import svga_hif_pkg::*;

   localparam int OFF_W = BANK_BITS + PAGE_SHIFT;

   logic             en_q;
   logic [IDX_W-1:0] idx_q;
   logic [7:0]       crtc_rd;
   logic [7:0]       mode_q, bank_q, aux_q;
   logic [OFF_W-1:0] off_q;
   logic [7:0]       mux_rd;

   svga_adapter_id u_id (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr    (io_wr && io_addr == PORT_ENABLE),
      .en_wdata (io_wdata[0]),
      .en_q     (en_q)
   );

   svga_crtc_file #(.IDX_W(IDX_W)) u_crtc (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_wr    (io_wr && io_addr == PORT_CRT_IDX),
      .idx_wdata (io_wdata[IDX_W-1:0]),
      .dat_wr    (io_wr && io_addr == PORT_CRT_DAT),
      .wdata     (io_wdata),
      .idx_q     (idx_q),
      .dat_rd    (crtc_rd),
      .regs_flat (crtc_regs),
      .recalc_q  (timing_recalc)
   );

   svga_ext_window #(.BANK_BITS(BANK_BITS), .PAGE_SHIFT(PAGE_SHIFT)) u_ext (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_wr  (io_wr && io_addr == PORT_MODE),
      .bank_wr  (io_wr && io_addr == PORT_BANK),
      .aux_wr   (io_wr && io_addr == PORT_AUX),
      .wdata    (io_wdata),
      .mode_q   (mode_q),
      .bank_q   (bank_q),
      .aux_q    (aux_q),
      .bank_off (off_q)
   );

   always_comb begin
      case (io_addr)
         PORT_ID_LO:   mux_rd = ID_LO_VALUE;
         PORT_ID_HI:   mux_rd = ID_HI_VALUE;
         PORT_ENABLE:  mux_rd = {7'b0, en_q};
         PORT_CRT_IDX: mux_rd = 8'(idx_q);
         PORT_CRT_DAT: mux_rd = crtc_rd;
         PORT_MODE:    mux_rd = mode_q;
         PORT_BANK:    mux_rd = bank_q;
         PORT_AUX:     mux_rd = aux_q;
         default:      mux_rd = 8'h00;
      endcase
   end

   if (GATE_RDATA) begin : g_gated
      assign io_rdata = io_rd ? mux_rd : 8'h00;
   end else begin : g_open
      assign io_rdata = mux_rd;
   end

   assign adapter_en  = en_q;
   assign bank_rd_off = off_q;
   assign bank_wr_off = off_q;

   AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr && io_addr == PORT_ENABLE |=> adapter_en == $past(io_wdata[0])); // R2
endmodule

// File: tb/svga_host_regs_tb.sv
module svga_host_regs_tb_top;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [15:0]  io_addr = '0;
   logic [7:0]   io_wdata = '0;
   logic         io_wr = 1'b0;
   logic         io_rd = 1'b0;
   logic [7:0]   io_rdata;
   logic         adapter_en;
   logic [18:0]  bank_rd_off, bank_wr_off;
   logic [255:0] crtc_regs;
   logic         timing_recalc;

   int checks = 0;
   int errors = 0;

   logic [7:0]  m_crtc [32];
   logic [5:0]  m_idx;
   logic        m_en;
   logic [7:0]  m_mode, m_bank, m_aux;
   logic [18:0] m_off;

   always #(CLK_PERIOD/2) clk = ~clk;

   svga_host_regs dut_i (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .adapter_en(adapter_en),
      .bank_rd_off(bank_rd_off), .bank_wr_off(bank_wr_off),
      .crtc_regs(crtc_regs), .timing_recalc(timing_recalc)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input logic [15:0] a);
      case (a)
         16'h0100: return 8'hFE;
         16'h0101: return 8'hE8;
         16'h0102: return {7'b0, m_en};
         16'h03D4: return {2'b0, m_idx};
         16'h03D5: return m_idx[5] ? 8'hFF : m_crtc[m_idx[4:0]];
         16'h2100: return m_mode;
         16'h2108: return m_bank;
         16'h210A: return m_aux;
         default:  return 8'h00;
      endcase
   endfunction

   function automatic string req_of(input logic [15:0] a);
      case (a)
         16'h0100, 16'h0101: return "R1";
         16'h0102:           return "R2";
         16'h03D4:           return "R3";
         16'h03D5:           return "R4";
         16'h2100, 16'h2108, 16'h210A: return "R9";
         default:            return "R11";
      endcase
   endfunction

   task automatic model_reset();
      foreach (m_crtc[i]) m_crtc[i] = 8'h00;
      m_idx = '0; m_en = 0; m_mode = 0; m_bank = 0; m_aux = 0; m_off = 0;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      logic exp_pulse = 1'b0;
      logic [4:0] s;
      logic [7:0] nv;
      logic lk;
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
      case (a)
         16'h0102: m_en = d[0];
         16'h03D4: m_idx = d[5:0];
         16'h03D5: if (!m_idx[5]) begin
            s  = m_idx[4:0];
            lk = m_crtc[17][7];
            if (!(lk && s <= 5'd6)) begin
               nv = (lk && s == 5'd7) ? ((m_crtc[7] & 8'hEF) | (d & 8'h10)) : d;
               exp_pulse = (nv != m_crtc[s]) && !(s >= 5'd14 && s <= 5'd16);
               m_crtc[s] = nv;
            end
         end
         16'h2100: begin
            m_mode = d;
            m_off  = (d[2:0] >= 3'd4) ? {m_bank[2:0], 16'h0} : 19'h0;
         end
         16'h2108: begin
            m_bank = d;
            if (m_mode[2:0] >= 3'd4) m_off = {d[2:0], 16'h0};
         end
         16'h210A: m_aux = d;
         default: ;
      endcase
      @(negedge clk);
      io_wr = 1'b0;
      chk("R6 timing_recalc", 32'(timing_recalc), 32'(exp_pulse));
      chk("R7/R8 bank_wr_off", 32'(bank_wr_off), 32'(m_off));
      chk("R9 bank_rd_off", 32'(bank_rd_off), 32'(bank_wr_off));
      chk("R2 adapter_en", 32'(adapter_en), 32'(m_en));
   endtask

   task automatic rd(input logic [15:0] a);
      @(negedge clk);
      io_addr = a; io_wr = 1'b0; io_rd = 1'b1;
      #1;
      chk(req_of(a), 32'(io_rdata), 32'(exp_rd(a)));
   endtask

   task automatic chk_flat(input string req);
      for (int i = 0; i < 32; i++) chk(req, 32'(crtc_regs[8*i +: 8]), 32'(m_crtc[i]));
   endtask

   function automatic logic [15:0] pick_addr();
      case ($urandom % 12)
         0: return 16'h0100;  1: return 16'h0101;  2: return 16'h0102;
         3, 4: return 16'h03D4;
         5, 6: return 16'h03D5;
         7: return 16'h2100;  8: return 16'h2108;  9: return 16'h210A;
         10: return 16'h2100 + 16'($urandom % 16);
         default: return 16'h03C7;
      endcase
   endfunction

   function automatic logic [7:0] pick_data(input logic [15:0] a);
      if (a == 16'h03D4) begin
         case ($urandom % 6)
            0: return 8'h11;
            1: return 8'h07;
            2: return 8'(14 + $urandom % 3);
            3: return 8'(8'h20 | ($urandom % 32));
            default: return 8'($urandom % 10);
         endcase
      end
      if (a == 16'h2100) return 8'($urandom % 8);
      return 8'($urandom);
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd5151));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R10 reset state
      chk("R10 recalc", 32'(timing_recalc), 0);
      chk("R10 offset", 32'(bank_wr_off), 0);
      chk("R10 enable", 32'(adapter_en), 0);
      chk_flat("R10 crtc");
      rd(16'h2100); rd(16'h2108); rd(16'h210A); rd(16'h03D4);

      // R11 read strobe low gives zero
      @(negedge clk); io_addr = 16'h0100; io_rd = 1'b0; #1;
      chk("R11 rdata idle", 32'(io_rdata), 0);

      // R1 identification ports ignore writes
      wr(16'h0100, 8'h12); wr(16'h0101, 8'h34);
      rd(16'h0100); rd(16'h0101);

      // R2 enable
      wr(16'h0102, 8'hFF); rd(16'h0102);
      wr(16'h0102, 8'hFE); rd(16'h0102);

      // R3 index masking, R4 hidden index
      wr(16'h03D4, 8'hFF); rd(16'h03D4);
      wr(16'h03D5, 8'h5A); rd(16'h03D5);
      chk_flat("R4 hidden write");

      // R6 change, repeat write, cursor index
      wr(16'h03D4, 8'h03); wr(16'h03D5, 8'hA5); wr(16'h03D5, 8'hA5); rd(16'h03D5);
      wr(16'h03D4, 8'h0E); wr(16'h03D5, 8'h77);
      wr(16'h03D4, 8'h10); wr(16'h03D5, 8'h66);
      wr(16'h03D4, 8'h11); wr(16'h03D5, 8'h01);

      // R5 lock: registers 0..6 closed, register 7 partial, register 8 open
      wr(16'h03D4, 8'h07); wr(16'h03D5, 8'hC3);
      wr(16'h03D4, 8'h11); wr(16'h03D5, 8'h80);
      wr(16'h03D4, 8'h06); wr(16'h03D5, 8'h99); rd(16'h03D5);
      wr(16'h03D4, 8'h00); wr(16'h03D5, 8'h11); rd(16'h03D5);
      wr(16'h03D4, 8'h07); wr(16'h03D5, 8'h3C); rd(16'h03D5);
      wr(16'h03D5, 8'h2C); rd(16'h03D5);
      wr(16'h03D4, 8'h08); wr(16'h03D5, 8'h44); rd(16'h03D5);
      wr(16'h03D4, 8'h11); wr(16'h03D5, 8'h00);
      chk_flat("R5 lock");

      // R7 / R8 mode and bank gating
      wr(16'h2108, 8'h05);      // mode linear: offset stays 0
      wr(16'h2100, 8'h04);      // banked: offset from stored bank
      wr(16'h2108, 8'hFB);      // banked: offset follows low 3 bits
      wr(16'h2100, 8'h0B);      // low bits 3: offset forced 0
      wr(16'h2100, 8'h07);
      rd(16'h2108); rd(16'h2100);
      wr(16'h210A, 8'h9D); rd(16'h210A);

      // R11 unused window ports
      wr(16'h2103, 8'hAB); rd(16'h2103); rd(16'h210F); rd(16'h3000);

      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] a = pick_addr();
         if ($urandom % 2) wr(a, pick_data(a));
         else              rd(a);
      end
      chk_flat("R12 crtc bus");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule